// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block sits between a USB host controller's schedule walker and its packet engine. For each transfer descriptor it receives the 32-bit control word, the 32-bit token word and the outcome of the bus transaction reported by the device side. From these it computes the control word to write back, a code for what the walker does next, and the interrupt causes raised by this descriptor. It also splits the token into the fields the packet engine needs.

The update follows the descriptor rules for each outcome. On success it records the length and retires the descriptor. A short IN packet holds the queue. A timeout consumes one unit of the error budget. A NAK leaves the descriptor active for a later retry. A stall retires it. Babble retires it and abandons the frame. A token with an unknown packet identifier abandons the frame without touching the descriptor. A write-back strobe asks for a memory write only when the word has actually changed.

There is one register stage. A request presented with `inValid` high produces its results one clock later with `outValid` high, and a new request may be presented on every cycle.

Top module: `tdu_status_updater`

## Requirements
- R1: The token is decoded as follows: packet identifier from bits 7:0, device address from bits 14:8 and endpoint from bits 18:15. The maximum length is (bits 31:21 + 1) modulo 2048, so the field value 0x7FF decodes to 0 bytes.
- R2: Every output is registered. Results appear on the clock edge after the one that samples `inValid`, and `outValid` is high exactly in those cycles. `outValid` is 0 after reset.
- R3: A descriptor with active (control bit 23) clear is returned unchanged, whatever its token or result. The action is HOLD and `writeBack` is 0. Action codes are ADVANCE=0, HOLD=1 and STOP=2.
- R4: `causeIoc` equals control bit 24 of the request for every outcome, including inactive descriptors and unknown packet identifiers.
- R5: Success (result code 0) writes (`resLen` − 1) modulo 2048 into bits 10:0, clears active and gives ADVANCE.
- R6: A successful IN (identifier 0x69) whose short-packet-detect bit 29 is set and whose `resLen` is below the maximum length raises `causeShort` and gives HOLD instead of ADVANCE. SETUP is 0x2D and OUT is 0xE1.
- R7: Timeout (result code 4) or no device (code 5) sets bit 18 and gives HOLD. It decrements the error count in bits 28:27 if that count is nonzero. When the decrement reaches 0, active is cleared and `usbErr` is raised. A count already at 0 is left at 0 and active stays set.
- R8: NAK (result code 1) sets bit 19, keeps active set and gives HOLD.
- R9: Stall (result code 2) sets bit 22, clears active and gives HOLD.
- R10: Babble (result code 3), or a successful IN whose `resLen` exceeds the maximum length, sets bits 20 and 22, clears active and gives STOP.
- R11: An active descriptor whose packet identifier is not SETUP, IN or OUT leaves the word unchanged, raises `procErr` and gives STOP.
- R12: `writeBack` is 1 exactly when `ctrlOut` differs from the request's control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| ctrlIn | input | 32 | Descriptor control word |
| tokenIn | input | 32 | Descriptor token word |
| resKind | input | 3 | Transaction result: 0 ok, 1 NAK, 2 stall, 3 babble, 4 timeout, 5 no device |
| resLen | input | 11 | Bytes actually transferred |
| outValid | output | 1 | Results valid |
| ctrlOut | output | 32 | Updated control word |
| writeBack | output | 1 | Control word changed; write it back |
| action | output | 2 | Next step: 0 advance, 1 hold, 2 stop frame |
| causeIoc | output | 1 | Completion interrupt cause |
| causeShort | output | 1 | Short-packet interrupt cause |
| usbErr | output | 1 | Error budget exhausted |
| procErr | output | 1 | Unknown packet identifier |
| pidOut | output | 8 | Decoded packet identifier |
| devAddr | output | 7 | Decoded device address |
| endPt | output | 4 | Decoded endpoint |
| maxLen | output | 11 | Decoded maximum length in bytes |

## Verification
A wrong decision in the control path shows up in the next result cycle, either as a mismatched action code or as a missing or spurious cause flag. A wrong strobe from the control path shows up in the same cycle as a wrong bit in `ctrlOut`, and usually also as a `writeBack` that disagrees with it. The error-count boundary is the one place where a fault needs a specific stimulus to appear. Counts of 3, 1 and 0 are driven so that an off-by-one in the countdown changes either the active bit or `usbErr` on that descriptor's own result. Back-to-back requests expose any stage that holds stale data from the request before.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 11;
  localparam int PID_W    = 8;
  localparam int ADDR_W   = 7;
  localparam int EP_W     = 4;
  localparam int RES_W    = 3;
  localparam int ACT_W    = 2;

  // control word bit positions (fixed by the descriptor format)
  localparam int B_SPD     = 29;
  localparam int B_ERR_HI  = 28;
  localparam int B_ERR_LO  = 27;
  localparam int B_IOC     = 24;
  localparam int B_ACTIVE  = 23;
  localparam int B_STALL   = 22;
  localparam int B_BABBLE  = 20;
  localparam int B_NAK     = 19;
  localparam int B_TIMEOUT = 18;

  // token field positions
  localparam int T_ADDR_LO = 8;
  localparam int T_EP_LO   = 15;
  localparam int T_LEN_LO  = 21;

  localparam logic [PID_W-1:0] PID_SETUP = 8'h2D;
  localparam logic [PID_W-1:0] PID_IN    = 8'h69;
  localparam logic [PID_W-1:0] PID_OUT   = 8'hE1;

  typedef enum logic [RES_W-1:0] {
    RES_OK      = 3'd0,
    RES_NAK     = 3'd1,
    RES_STALL   = 3'd2,
    RES_BABBLE  = 3'd3,
    RES_TIMEOUT = 3'd4,
    RES_NODEV   = 3'd5
  } resKind_e;

  typedef enum logic [ACT_W-1:0] {
    ACT_ADVANCE = 2'd0,
    ACT_HOLD    = 2'd1,
    ACT_STOP    = 2'd2
  } action_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLen;
    logic clearActive;
    logic setTimeout;
    logic setNak;
    logic setStall;
    logic setBabble;
    logic decErr;
  } strobes_t;
endpackage

// File: rtl/tdu_datapath.sv
module tdu_datapath
  import tdu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] ctrlIn,
  input  logic [WORD_W-1:0] tokenIn,
  input  logic [LEN_W-1:0]  resLen,
  input  strobes_t          strb,
  output logic [PID_W-1:0]  pidDec,
  output logic [LEN_W-1:0]  maxLenDec,
  output logic [WORD_W-1:0] ctrlOutQ,
  output logic              writeBackQ,
  output logic [PID_W-1:0]  pidQ,
  output logic [ADDR_W-1:0] devAddrQ,
  output logic [EP_W-1:0]   endPtQ,
  output logic [LEN_W-1:0]  maxLenQ
);
  localparam int ERR_W = B_ERR_HI - B_ERR_LO + 1;

  logic [ADDR_W-1:0] addrDec;
  logic [EP_W-1:0]   epDec;
  logic [WORD_W-1:0] ctrlNext;
  logic [ERR_W-1:0]  errCnt;

  always_comb begin
    pidDec    = tokenIn[PID_W-1:0];
    addrDec   = tokenIn[T_ADDR_LO +: ADDR_W];
    epDec     = tokenIn[T_EP_LO +: EP_W];
    maxLenDec = tokenIn[T_LEN_LO +: LEN_W] + LEN_W'(1);
  end

  always_comb begin
    ctrlNext = ctrlIn;
    errCnt   = ctrlIn[B_ERR_HI:B_ERR_LO];
    if (strb.loadLen)     ctrlNext[LEN_W-1:0] = resLen - LEN_W'(1);
    if (strb.clearActive) ctrlNext[B_ACTIVE]  = 1'b0;
    if (strb.setTimeout)  ctrlNext[B_TIMEOUT] = 1'b1;
    if (strb.setNak)      ctrlNext[B_NAK]     = 1'b1;
    if (strb.setStall)    ctrlNext[B_STALL]   = 1'b1;
    if (strb.setBabble)   ctrlNext[B_BABBLE]  = 1'b1;
    if (strb.decErr)      ctrlNext[B_ERR_HI:B_ERR_LO] = errCnt - ERR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlOutQ   <= '0;
      writeBackQ <= 1'b0;
      pidQ       <= '0;
      devAddrQ   <= '0;
      endPtQ     <= '0;
      maxLenQ    <= '0;
    end else if (inValid) begin
      ctrlOutQ   <= ctrlNext;
      writeBackQ <= (ctrlNext != ctrlIn);
      pidQ       <= pidDec;
      devAddrQ   <= addrDec;
      endPtQ     <= epDec;
      maxLenQ    <= maxLenDec;
    end
  end
endmodule

// File: rtl/tdu_ctrl.sv
module tdu_ctrl
  import tdu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             activeIn,
  input  logic             iocIn,
  input  logic             spdIn,
  input  logic [1:0]       errCntIn,
  input  logic [PID_W-1:0] pidDec,
  input  logic [LEN_W-1:0] maxLenDec,
  input  logic [RES_W-1:0] resKind,
  input  logic [LEN_W-1:0] resLen,
  output strobes_t         strb,
  output logic             validQ,
  output logic [ACT_W-1:0] actionQ,
  output logic             causeIocQ,
  output logic             causeShortQ,
  output logic             usbErrQ,
  output logic             procErrQ
);
  logic    pidKnown, isIn, overrun;
  action_e actNext;
  logic    shortNext, usbErrNext, procErrNext;

  always_comb begin
    isIn     = (pidDec == PID_IN);
    pidKnown = (pidDec == PID_SETUP) || isIn || (pidDec == PID_OUT);
    overrun  = isIn && (resLen > maxLenDec);
  end

  always_comb begin
    strb        = '0;
    actNext     = ACT_HOLD;
    shortNext   = 1'b0;
    usbErrNext  = 1'b0;
    procErrNext = 1'b0;
    if (!activeIn) begin
      actNext = ACT_HOLD;
    end else if (!pidKnown) begin
      procErrNext = 1'b1;
      actNext     = ACT_STOP;
    end else begin
      case (resKind_e'(resKind))
        RES_OK: begin
          if (overrun) begin
            strb.setBabble   = 1'b1;
            strb.setStall    = 1'b1;
            strb.clearActive = 1'b1;
            actNext          = ACT_STOP;
          end else begin
            strb.loadLen     = 1'b1;
            strb.clearActive = 1'b1;
            actNext          = ACT_ADVANCE;
            if (isIn && spdIn && (resLen < maxLenDec)) begin
              shortNext = 1'b1;
              actNext   = ACT_HOLD;
            end
          end
        end
        RES_NAK: begin
          strb.setNak = 1'b1;
        end
        RES_STALL: begin
          strb.setStall    = 1'b1;
          strb.clearActive = 1'b1;
        end
        RES_BABBLE: begin
          strb.setBabble   = 1'b1;
          strb.setStall    = 1'b1;
          strb.clearActive = 1'b1;
          actNext          = ACT_STOP;
        end
        default: begin
          strb.setTimeout = 1'b1;
          if (errCntIn != 2'd0) strb.decErr = 1'b1;
          if (errCntIn == 2'd1) begin
            strb.clearActive = 1'b1;
            usbErrNext       = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ      <= 1'b0;
      actionQ     <= ACT_HOLD;
      causeIocQ   <= 1'b0;
      causeShortQ <= 1'b0;
      usbErrQ     <= 1'b0;
      procErrQ    <= 1'b0;
    end else begin
      validQ <= inValid;
      if (inValid) begin
        actionQ     <= actNext;
        causeIocQ   <= iocIn;
        causeShortQ <= shortNext;
        usbErrQ     <= usbErrNext;
        procErrQ    <= procErrNext;
      end
    end
  end
endmodule

// File: rtl/tdu_status_updater.sv
module tdu_status_updater
  import tdu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] ctrlIn,
  input  logic [31:0] tokenIn,
  input  logic [2:0]  resKind,
  input  logic [10:0] resLen,
  output logic        outValid,
  output logic [31:0] ctrlOut,
  output logic        writeBack,
  output logic [1:0]  action,
  output logic        causeIoc,
  output logic        causeShort,
  output logic        usbErr,
  output logic        procErr,
  output logic [7:0]  pidOut,
  output logic [6:0]  devAddr,
  output logic [3:0]  endPt,
  output logic [10:0] maxLen
);
  strobes_t         strb;
  logic [PID_W-1:0] pidDec;
  logic [LEN_W-1:0] maxLenDec;

  tdu_datapath uDp (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .ctrlIn(ctrlIn), .tokenIn(tokenIn), .resLen(resLen), .strb(strb),
    .pidDec(pidDec), .maxLenDec(maxLenDec),
    .ctrlOutQ(ctrlOut), .writeBackQ(writeBack),
    .pidQ(pidOut), .devAddrQ(devAddr), .endPtQ(endPt), .maxLenQ(maxLen)
  );

  tdu_ctrl uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .activeIn(ctrlIn[B_ACTIVE]), .iocIn(ctrlIn[B_IOC]), .spdIn(ctrlIn[B_SPD]),
    .errCntIn(ctrlIn[B_ERR_HI:B_ERR_LO]),
    .pidDec(pidDec), .maxLenDec(maxLenDec),
    .resKind(resKind), .resLen(resLen),
    .strb(strb), .validQ(outValid), .actionQ(action),
    .causeIocQ(causeIoc), .causeShortQ(causeShort),
    .usbErrQ(usbErr), .procErrQ(procErr)
  );
endmodule

// File: rtl/tdu_checker.sv
module tdu_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] ctrlIn,
  input logic        outValid,
  input logic [31:0] ctrlOut,
  input logic        writeBack,
  input logic [1:0]  action,
  input logic        causeIoc,
  input logic        usbErr,
  input logic        procErr
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2

  AST_INACTIVE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ctrlIn[23]) |=> (ctrlOut == $past(ctrlIn) && action == 2'd1 && !writeBack)); // R3

  AST_IOC_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (causeIoc == $past(ctrlIn[24]))); // R4

  AST_USBERR_EXHAUSTED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && usbErr) |-> (ctrlOut[28:27] == 2'd0 && !ctrlOut[23] && ctrlOut[18])); // R7

  AST_BABBLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ctrlOut[20] && action == 2'd2) |-> (ctrlOut[22] && !ctrlOut[23])); // R10

  AST_PROCERR_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && procErr) |-> (action == 2'd2 && !writeBack)); // R11

  AST_WB_CHANGED: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (writeBack == (ctrlOut != $past(ctrlIn)))); // R12
endmodule

bind tdu_status_updater tdu_checker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .ctrlIn(ctrlIn),
  .outValid(outValid), .ctrlOut(ctrlOut), .writeBack(writeBack),
  .action(action), .causeIoc(causeIoc), .usbErr(usbErr), .procErr(procErr)
);

// File: tb/tb_tdu_status_updater.sv
module tb_tdu_status_updater;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] ctrlIn = '0;
  logic [31:0] tokenIn = '0;
  logic [2:0]  resKind = '0;
  logic [10:0] resLen = '0;
  logic        outValid, writeBack, causeIoc, causeShort, usbErr, procErr;
  logic [31:0] ctrlOut;
  logic [1:0]  action;
  logic [7:0]  pidOut;
  logic [6:0]  devAddr;
  logic [3:0]  endPt;
  logic [10:0] maxLen;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] ctrl;
    logic        wb;
    logic [1:0]  act;
    logic        ioc, sh, ue, pe;
    logic [7:0]  pid;
    logic [6:0]  addr;
    logic [3:0]  ep;
    logic [10:0] ml;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  tdu_status_updater dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrlIn(ctrlIn),
    .tokenIn(tokenIn), .resKind(resKind), .resLen(resLen),
    .outValid(outValid), .ctrlOut(ctrlOut), .writeBack(writeBack),
    .action(action), .causeIoc(causeIoc), .causeShort(causeShort),
    .usbErr(usbErr), .procErr(procErr), .pidOut(pidOut),
    .devAddr(devAddr), .endPt(endPt), .maxLen(maxLen)
  );

  function automatic exp_t model(input logic [31:0] c, input logic [31:0] t,
                                 input logic [2:0] r, input logic [10:0] n,
                                 input string tag);
    exp_t e;
    logic [1:0] cnt;
    logic       isIn;
    e.tag  = tag;
    e.pid  = t[7:0];
    e.addr = t[14:8];
    e.ep   = t[18:15];
    e.ml   = 11'(t[31:21] + 11'd1);
    e.ctrl = c;
    e.act  = 2'd1;
    e.ioc  = c[24];
    e.sh = 1'b0; e.ue = 1'b0; e.pe = 1'b0;
    isIn = (e.pid == 8'h69);
    if (c[23]) begin
      if (!(e.pid == 8'h2D || isIn || e.pid == 8'hE1)) begin
        e.pe = 1'b1; e.act = 2'd2;
      end else if (r == 3'd3 || (r == 3'd0 && isIn && n > e.ml)) begin
        e.ctrl[20] = 1'b1; e.ctrl[22] = 1'b1; e.ctrl[23] = 1'b0; e.act = 2'd2;
      end else if (r == 3'd0) begin
        e.ctrl[10:0] = n - 11'd1; e.ctrl[23] = 1'b0; e.act = 2'd0;
        if (isIn && c[29] && n < e.ml) begin e.sh = 1'b1; e.act = 2'd1; end
      end else if (r == 3'd1) begin
        e.ctrl[19] = 1'b1;
      end else if (r == 3'd2) begin
        e.ctrl[22] = 1'b1; e.ctrl[23] = 1'b0;
      end else begin
        e.ctrl[18] = 1'b1;
        cnt = c[28:27];
        if (cnt != 2'd0) begin
          cnt = cnt - 2'd1;
          e.ctrl[28:27] = cnt;
          if (cnt == 2'd0) begin e.ctrl[23] = 1'b0; e.ue = 1'b1; end
        end
      end
    end
    e.wb = (e.ctrl != c);
    return e;
  endfunction

  task automatic drive(input logic [31:0] c, input logic [31:0] t,
                       input logic [2:0] r, input logic [10:0] n, input string tag);
    sb.push_back(model(c, t, r, n, tag));
    ctrlIn = c; tokenIn = t; resKind = r; resLen = n; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor: compares each result against the oldest expected item
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected outValid, actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (ctrlOut !== e.ctrl || writeBack !== e.wb || action !== e.act ||
            causeIoc !== e.ioc || causeShort !== e.sh || usbErr !== e.ue ||
            procErr !== e.pe || pidOut !== e.pid || devAddr !== e.addr ||
            endPt !== e.ep || maxLen !== e.ml) begin
          errors++;
          $display("FAIL %s: actual ctrl=%h wb=%b act=%0d ioc=%b sh=%b ue=%b pe=%b pid=%h addr=%h ep=%h ml=%h expected ctrl=%h wb=%b act=%0d ioc=%b sh=%b ue=%b pe=%b pid=%h addr=%h ep=%h ml=%h",
                   e.tag, ctrlOut, writeBack, action, causeIoc, causeShort, usbErr,
                   procErr, pidOut, devAddr, endPt, maxLen, e.ctrl, e.wb, e.act,
                   e.ioc, e.sh, e.ue, e.pe, e.pid, e.addr, e.ep, e.ml);
        end
      end
    end
  end

  localparam logic [31:0] ACT3   = 32'h1880_0000; // active, error count 3
  localparam logic [31:0] TOK_IN = 32'h00E1_0569; // IN, addr 5, ep 2, max 8
  localparam logic [31:0] TOK_OUT= 32'h00E1_05E1; // OUT, addr 5, ep 2, max 8
  localparam logic [31:0] TOK_SU = 32'h00E1_052D; // SETUP, max 8

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        checks++;
        if (outValid !== 1'b0) begin
          errors++;
          $display("FAIL R2: outValid in reset actual=%b expected=0", outValid);
        end
        rstN = 1'b1;
        @(negedge clk);
        drive(ACT3, TOK_OUT, 3'd0, 11'd8, "R5 R1 out success");
        drive(ACT3, TOK_SU, 3'd0, 11'd0, "R5 zero length");
        drive(ACT3 | 32'h2000_0000, TOK_IN, 3'd0, 11'd3, "R6 short in");
        drive(ACT3 | 32'h2000_0000, TOK_IN, 3'd0, 11'd8, "R6 full in advances");
        drive(ACT3, TOK_IN, 3'd0, 11'd9, "R10 in overrun");
        drive(ACT3, TOK_OUT, 3'd3, 11'd0, "R10 babble");
        drive(ACT3, TOK_IN, 3'd2, 11'd0, "R9 stall");
        drive(ACT3, TOK_SU, 3'd1, 11'd0, "R8 nak");
        drive(ACT3, TOK_IN, 3'd4, 11'd0, "R7 timeout count 3");
        drive(32'h0880_0000, TOK_IN, 3'd4, 11'd0, "R7 timeout count 1");
        drive(32'h0080_0000, TOK_OUT, 3'd5, 11'd0, "R7 nodev count 0");
        drive(32'h0100_0000, 32'h0000_0055, 3'd3, 11'd0, "R3 R4 inactive");
        drive(32'h0180_0000, 32'h0000_0055, 3'd0, 11'd0, "R11 R4 bad pid");
        drive(ACT3, 32'hFFFF_FF69, 3'd0, 11'd0, "R1 max field zero length");
        drive(32'h0088_0000, TOK_IN, 3'd1, 11'd0, "R12 nak unchanged");
        drive(32'h2180_0005, TOK_OUT, 3'd0, 11'd5, "R12 success same length");
        repeat (2) @(negedge clk);
        checks++;
        if (outValid !== 1'b0 || sb.size() != 0) begin
          errors++;
          $display("FAIL R2: idle outValid actual=%b pending=%0d expected=0 0",
                   outValid, sb.size());
        end
      end
      begin
        repeat (5000) @(negedge clk);
        checks++;
        errors++;
        $display("FAIL R2: watchdog expired actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule